// File: doc/BRIEF.md
# Boot-Time Memory Sizing and Page-Map Builder

This block runs once after power-up to find out which physical pages of memory really respond, and to fill a virtual-to-real page map from what it finds. It drives a single word-wide master port into memory. The upper address bit selects the map region, and the lower bits select the first word of a physical page. A page holds 256 words. A page number is the bank number followed by the page-within-bank index.

A pulse on `start` begins the sequence. First, every page from the top of the configured memory down to page 0 gets its own page number written into its first word. Because the writes run downward, an address that aliases onto a lower page ends up holding the lowest page number. Second, every map slot is written with a vacant marker. Third, the scan walks upward from a first real page and reads back each tag. A page is real only when the tag reads back intact and without an uncorrectable error. Real pages are written into consecutive map slots, with the present flag set. One reserved I/O page is never taken from the scan. Instead, its entry goes into a fixed virtual slot, and the real page under consideration moves on to the following slot. At the end, `done` pulses and `next_free` reports the first unused slot.

The request channel is valid/ready. While `mem_req_valid` is high and `mem_req_ready` is low, the block keeps the request and its address, write flag and data unchanged, and a request is taken on the edge where both are high. Writes complete at acceptance. A read waits for a single-cycle `mem_rsp_valid`, which may come any number of cycles later, and the block issues no further request until it arrives. The response channel has no back-pressure.

Top module: `pmb_page_map_builder`

## Requirements
- R1: After reset, no request is valid, `done` and `halted` are low and `next_free` is 0.
- R2: After `start`, the first phase writes the value p into address {0, p, 8'h00} for every page p from TOP_BANK*2^PIW-1 down to 0, in strictly descending order, one write per page.
- R3: Before any read is issued, every map slot k in 0..MAP_ENTRIES-1 is written with VACANT at address {1, k}.
- R4: The scan reads pages from FIRST_PAGE upward and stops below page SMALL_BANK*2^PIW when `small_mode` was high at `start`, otherwise below TOP_BANK*2^PIW. No page outside that range is read.
- R5: A scanned page is real only when its response has `mem_rsp_ecc_err` low and `mem_rsp_rdata` equals its page number. Any other page is skipped and the scan continues.
- R6: The real page equal to IO_PAGE never gets a map entry of its own from the scan.
- R7: When the slot to be filled is IO_SLOT, that slot receives IO_PAGE with the present flag (bit DATA_W-1) set. The pending real page then goes into the next slot.
- R8: Every other real page p is written, in ascending order, into consecutive map slots as p with bit DATA_W-1 set.
- R9: When all MAP_ENTRIES slots have been filled, the scan ends even if pages remain to be read.
- R10: A read response with `mem_rsp_fatal` high moves the block into a halt. In the halt, `halted` stays high, no further request is issued and `done` never pulses, until reset.
- R11: On completion, `done` is high for exactly one cycle. During that cycle `next_free` equals the number of slots holding present entries, and it keeps that value until the next `start`.
- R12: A request not yet accepted keeps its valid, address, write flag and data unchanged. Reads tolerate any response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sizing run (taken while idle) |
| small_mode | input | 1 | Limit the scan to the small-memory bank bound |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address; top bit selects the map region |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | DATA_W | Read data |
| mem_rsp_ecc_err | input | 1 | Uncorrectable error on this read (page absent) |
| mem_rsp_fatal | input | 1 | Out-of-range fault on this read (halt) |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Fatal halt reached |
| next_free | output | SL_W | Index of the first unused map slot |

## Verification
The hardest situation to reach is the real page that is pending at the moment the scan arrives at the reserved I/O slot. The I/O entry must be inserted there without losing or repeating that page. This has to happen together with aliased pages, error-flagged pages and the reserved I/O page itself, which are all skipped. The bench models memory that wraps at a power-of-two size, an installed-size cutoff and a random set of failing pages. It sets these so that the skipped pages fall before, on and after the I/O slot, and it applies random ready stalls and response latencies over several seeded runs. A fatal response on a chosen page drives the halt path.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TAG,
    ST_VAC,
    ST_SCAN_REQ,
    ST_SCAN_WAIT,
    ST_MAP_IO,
    ST_MAP_PG,
    ST_DONE,
    ST_HALT
  } pmb_state_e;
endpackage

// File: rtl/pmb_cursor.sv
module pmb_cursor #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_up,
  input  logic         step_dn,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (load)    value <= load_val;
    else if (step_up) value <= value + W'(1);
    else if (step_dn) value <= value - W'(1);
  end
endmodule

// File: rtl/pmb_entry_fmt.sv
module pmb_entry_fmt #(
  parameter int PN_W     = 16,
  parameter int SL_W     = 13,
  parameter int DATA_W   = 32,
  parameter int IO_PAGE  = 'h140,
  parameter int IO_SLOT  = 'h40
) (
  input  logic [PN_W-1:0]   page,
  input  logic [SL_W-1:0]   slot,
  input  logic [DATA_W-1:0] rdata,
  input  logic              ecc_err,
  output logic              tag_ok,
  output logic              is_io_page,
  output logic              slot_is_io,
  output logic [DATA_W-1:0] tag_word,
  output logic [DATA_W-1:0] page_entry,
  output logic [DATA_W-1:0] io_entry
);
  localparam logic [DATA_W-1:0] PRESENT = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    tag_word   = DATA_W'(page);
    tag_ok     = !ecc_err && (rdata == tag_word);
    is_io_page = (page == PN_W'(IO_PAGE));
    slot_is_io = (slot == SL_W'(IO_SLOT));
    page_entry = tag_word | PRESENT;
    io_entry   = DATA_W'(PN_W'(IO_PAGE)) | PRESENT;
  end
endmodule

// File: rtl/pmb_req_mux.sv
module pmb_req_mux
  import pmb_pkg::*;
#(
  parameter int PN_W   = 16,
  parameter int SL_W   = 13,
  parameter int ADDR_W = 25,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VACANT = '0
) (
  input  pmb_state_e        state,
  input  logic              scan_go,
  input  logic [PN_W-1:0]   page,
  input  logic [SL_W-1:0]   slot,
  input  logic [DATA_W-1:0] tag_word,
  input  logic [DATA_W-1:0] page_entry,
  input  logic [DATA_W-1:0] io_entry,
  output logic              req_valid,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);
  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] slot_addr;

  always_comb begin
    page_addr = {1'b0, page, 8'h00};
    slot_addr = {1'b1, (ADDR_W-1)'(slot)};
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    unique case (state)
      ST_TAG: begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = page_addr; req_wdata = tag_word;
      end
      ST_VAC: begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = slot_addr; req_wdata = VACANT;
      end
      ST_SCAN_REQ: begin
        req_valid = scan_go; req_addr = page_addr;
      end
      ST_MAP_IO: begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = slot_addr; req_wdata = io_entry;
      end
      ST_MAP_PG: begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = slot_addr; req_wdata = page_entry;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmb_page_map_builder.sv
module pmb_page_map_builder
  import pmb_pkg::*;
#(
  parameter int BANK_W      = 8,
  parameter int PIW         = 8,
  parameter int DATA_W      = 32,
  parameter int TOP_BANK    = 'h90,
  parameter int SMALL_BANK  = 'h0C,
  parameter int FIRST_PAGE  = 'h100,
  parameter int IO_PAGE     = 'h140,
  parameter int IO_SLOT     = 'h40,
  parameter int MAP_ENTRIES = 4096,
  parameter logic [DATA_W-1:0] VACANT = '0,
  localparam int PN_W   = BANK_W + PIW,
  localparam int ADDR_W = PN_W + 9,
  localparam int SL_W   = $clog2(MAP_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              small_mode,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              mem_rsp_ecc_err,
  input  logic              mem_rsp_fatal,
  output logic              done,
  output logic              halted,
  output logic [SL_W-1:0]   next_free
);
  localparam int LIM_W     = PN_W + 1;
  localparam int TOP_PAGES = TOP_BANK << PIW;
  localparam int SML_PAGES = SMALL_BANK << PIW;

  pmb_state_e        state_q, state_d;
  logic              small_q;
  logic [SL_W-1:0]   free_q;
  logic [PN_W-1:0]   page;
  logic [SL_W-1:0]   slot;
  logic              pg_load, pg_up, pg_dn;
  logic [PN_W-1:0]   pg_val;
  logic              sl_load, sl_up;
  logic              hs, scan_go, slots_full, slot_last;
  logic [LIM_W-1:0]  limit_page;
  logic              tag_ok, is_io_page, slot_is_io;
  logic [DATA_W-1:0] tag_word, page_entry, io_entry;

  pmb_cursor #(.W(PN_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(pg_load), .load_val(pg_val),
    .step_up(pg_up), .step_dn(pg_dn), .value(page)
  );

  pmb_cursor #(.W(SL_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(sl_load), .load_val('0),
    .step_up(sl_up), .step_dn(1'b0), .value(slot)
  );

  pmb_entry_fmt #(
    .PN_W(PN_W), .SL_W(SL_W), .DATA_W(DATA_W), .IO_PAGE(IO_PAGE), .IO_SLOT(IO_SLOT)
  ) u_fmt (
    .page(page), .slot(slot), .rdata(mem_rsp_rdata), .ecc_err(mem_rsp_ecc_err),
    .tag_ok(tag_ok), .is_io_page(is_io_page), .slot_is_io(slot_is_io),
    .tag_word(tag_word), .page_entry(page_entry), .io_entry(io_entry)
  );

  pmb_req_mux #(
    .PN_W(PN_W), .SL_W(SL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VACANT(VACANT)
  ) u_mux (
    .state(state_q), .scan_go(scan_go), .page(page), .slot(slot),
    .tag_word(tag_word), .page_entry(page_entry), .io_entry(io_entry),
    .req_valid(mem_req_valid), .req_we(mem_req_we),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata)
  );

  assign limit_page = small_q ? LIM_W'(SML_PAGES) : LIM_W'(TOP_PAGES);
  assign slots_full = (slot == SL_W'(MAP_ENTRIES));
  assign slot_last  = (slot == SL_W'(MAP_ENTRIES - 1));
  assign scan_go    = ({1'b0, page} < limit_page) && !slots_full;
  assign hs         = mem_req_valid && mem_req_ready;

  always_comb begin
    state_d = state_q;
    pg_load = 1'b0; pg_val = '0; pg_up = 1'b0; pg_dn = 1'b0;
    sl_load = 1'b0; sl_up = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        pg_load = 1'b1; pg_val = PN_W'(TOP_PAGES - 1);
        sl_load = 1'b1;
        state_d = ST_TAG;
      end
      ST_TAG: if (hs) begin
        if (page == '0) state_d = ST_VAC;
        else            pg_dn = 1'b1;
      end
      ST_VAC: if (hs) begin
        if (slot_last) begin
          sl_load = 1'b1;
          pg_load = 1'b1; pg_val = PN_W'(FIRST_PAGE);
          state_d = ST_SCAN_REQ;
        end else begin
          sl_up = 1'b1;
        end
      end
      ST_SCAN_REQ: begin
        if (!scan_go)  state_d = ST_DONE;
        else if (hs)   state_d = ST_SCAN_WAIT;
      end
      ST_SCAN_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_fatal)              state_d = ST_HALT;
        else if (tag_ok && !is_io_page) state_d = slot_is_io ? ST_MAP_IO : ST_MAP_PG;
        else begin
          pg_up   = 1'b1;
          state_d = ST_SCAN_REQ;
        end
      end
      ST_MAP_IO: if (hs) begin
        sl_up   = 1'b1;
        state_d = slot_last ? ST_DONE : ST_MAP_PG;
      end
      ST_MAP_PG: if (hs) begin
        sl_up   = 1'b1;
        pg_up   = 1'b1;
        state_d = ST_SCAN_REQ;
      end
      ST_DONE: state_d = ST_IDLE;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      small_q <= 1'b0;
      free_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        small_q <= small_mode;
        free_q  <= '0;
      end
      if (state_q == ST_DONE) free_q <= slot;
    end
  end

  assign done      = (state_q == ST_DONE);
  assign halted    = (state_q == ST_HALT);
  assign next_free = done ? slot : free_q;
endmodule

// File: rtl/pmb_checker.sv
module pmb_checker #(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 32,
  parameter int SL_W   = 13,
  parameter logic [DATA_W-1:0] VACANT = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              done,
  input logic              halted,
  input logic [SL_W-1:0]   next_free
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_FREE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !done |=> done || $stable(next_free)); // R11

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req_valid && !done); // R10

  AST_TAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && !mem_req_addr[ADDR_W-1]
      |-> mem_req_wdata == DATA_W'(mem_req_addr[ADDR_W-2:8])); // R2

  AST_MAP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_addr[ADDR_W-1]
      |-> mem_req_wdata[DATA_W-1] || mem_req_wdata == VACANT); // R8
endmodule

bind pmb_page_map_builder pmb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SL_W(SL_W), .VACANT(VACANT)
) u_pmb_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .done(done), .halted(halted), .next_free(next_free)
);

// File: tb/pmb_page_map_builder_tb_top.sv
module pmb_page_map_builder_tb_top;
  localparam int BANK_W = 4, PIW = 3, DATA_W = 16;
  localparam int TOPB = 8, SMLB = 3, FIRST = 8, IOP = 10, IOS = 3, NENT = 40;
  localparam logic [15:0] VAC = 16'h0BAD;
  localparam logic [15:0] PRES = 16'h8000;
  localparam int PN_W = BANK_W + PIW, ADDR_W = PN_W + 9, SL_W = $clog2(NENT + 1);
  localparam int TOPP = TOPB << PIW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, small_mode = 1'b0;
  logic mem_req_valid, mem_req_we, done, halted;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_ecc_err = 1'b0, mem_rsp_fatal = 1'b0;
  logic [DATA_W-1:0] mem_rsp_rdata = '0;
  logic [SL_W-1:0] next_free;

  always #10 clk = ~clk;

  pmb_page_map_builder #(
    .BANK_W(BANK_W), .PIW(PIW), .DATA_W(DATA_W), .TOP_BANK(TOPB), .SMALL_BANK(SMLB),
    .FIRST_PAGE(FIRST), .IO_PAGE(IOP), .IO_SLOT(IOS), .MAP_ENTRIES(NENT), .VACANT(VAC)
  ) dut_i (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] phys [128];
  logic [15:0] mapm [64];
  bit          badp [128];
  logic [15:0] expm [NENT];
  int exp_n;
  int m_alias, m_inst, m_fatal, m_lim;
  int tag_cnt, tag_order_err, last_tag, vac_cnt, rd_early, rd_oob, req_halt, done_cnt;
  bit pend; int pend_lat; logic [15:0] pend_d; bit pend_e, pend_f;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: drives at negedges, a request accepted at the following posedge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0; mem_rsp_ecc_err = 1'b0; mem_rsp_fatal = 1'b0;
    if (pend) begin
      if (pend_lat == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_rdata = pend_d;
        mem_rsp_ecc_err = pend_e; mem_rsp_fatal = pend_f; pend = 1'b0;
      end else pend_lat--;
    end
    mem_req_ready = ($urandom_range(3) != 0);
    if (done) done_cnt++;
    if (halted && mem_req_valid) req_halt++;
    if (mem_req_valid && mem_req_ready) begin
      int pg, q;
      pg = int'(mem_req_addr[ADDR_W-2:8]);
      q  = pg & (m_alias - 1);
      if (mem_req_addr[ADDR_W-1]) begin
        int idx;
        idx = int'(mem_req_addr[ADDR_W-2:0]);
        if (idx < 64) mapm[idx] = mem_req_wdata;
        if (mem_req_wdata == VAC) vac_cnt++;
      end else if (mem_req_we) begin
        tag_cnt++;
        if (pg != last_tag - 1) tag_order_err++;
        last_tag = pg;
        if (q < m_inst) phys[q] = mem_req_wdata;
      end else begin
        if (vac_cnt < NENT) rd_early++;
        if (pg < FIRST || pg >= m_lim) rd_oob++;
        pend = 1'b1; pend_lat = $urandom_range(3);
        pend_d = (q < m_inst) ? phys[q] : 16'h7FFF;
        pend_e = badp[pg]; pend_f = (pg == m_fatal);
      end
    end
  end

  task automatic calc_exp();
    exp_n = 0;
    for (int p = FIRST; p < m_lim; p++) begin
      bit real_pg;
      real_pg = (p < m_alias) && (p < m_inst) && !badp[p];
      if (real_pg && p != IOP && exp_n < NENT) begin
        if (exp_n == IOS) begin expm[exp_n] = 16'(IOP) | PRES; exp_n++; end
        if (exp_n < NENT) begin expm[exp_n] = 16'(p) | PRES; exp_n++; end
      end
    end
  endtask

  task automatic run_case(input int al, input int inst, input bit sm, input int fat, input int badpct);
    int w;
    m_alias = al; m_inst = inst; m_fatal = fat;
    m_lim = sm ? (SMLB << PIW) : TOPP;
    for (int i = 0; i < 128; i++) begin
      phys[i] = 16'h7FFF;
      badp[i] = ($urandom_range(99) < badpct);
    end
    for (int i = 0; i < 64; i++) mapm[i] = 16'hFFFF;
    tag_cnt = 0; tag_order_err = 0; last_tag = TOPP; vac_cnt = 0;
    rd_early = 0; rd_oob = 0; req_halt = 0; done_cnt = 0;
    calc_exp();
    @(negedge clk); start = 1'b1; small_mode = sm;
    @(negedge clk); start = 1'b0; small_mode = $urandom_range(1);
    w = 0;
    while (!done && !halted && w < 5000) begin @(negedge clk); w++; end
    if (fat >= 0) begin
      chk(halted, "R10 halt on fatal", halted, 1);
      repeat (30) @(negedge clk);
      chk(halted && req_halt == 0 && done_cnt == 0, "R10 quiet halt", req_halt + done_cnt, 0);
      return;
    end
    chk(done, "R11 done seen", done, 1);
    chk(next_free == SL_W'(exp_n), "R11/R9 next_free", next_free, exp_n);
    chk(tag_cnt == TOPP && tag_order_err == 0, "R2 tag sweep", tag_cnt, TOPP);
    chk(vac_cnt == NENT && rd_early == 0, "R3 vacant fill", vac_cnt, NENT);
    chk(rd_oob == 0, "R4 scan range", rd_oob, 0);
    for (int s = 0; s < NENT; s++) begin
      if (s >= exp_n)
        chk(mapm[s] == VAC, "R4/R9 unused slot vacant", mapm[s], VAC);
      else if (s == IOS)
        chk(mapm[s] == expm[s], "R7 io slot", mapm[s], expm[s]);
      else
        chk(mapm[s] == expm[s], "R5/R6/R8/R12 slot entry", mapm[s], expm[s]);
    end
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R11 single pulse", done_cnt, 1);
    chk(next_free == SL_W'(exp_n), "R11 next_free held", next_free, exp_n);
  endtask

  initial begin
    void'($urandom(32'd2024));
    pend = 1'b0; m_alias = 64; m_inst = 64; m_fatal = -1; m_lim = TOPP;
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !done && !halted && next_free == '0, "R1 reset state",
        {mem_req_valid, done, halted}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(64, 64, 1'b0, -1, 0);   // fills every slot (R9)
    run_case(64, 64, 1'b1, -1, 0);   // small-memory limit (R4)
    run_case(32, 64, 1'b0, -1, 10);  // aliasing plus error pages (R5)
    run_case(64, 20, 1'b0, -1, 0);   // odd installed size
    run_case(64, 12, 1'b0, -1, 0);   // too few pages to reach the io slot
    for (int k = 0; k < 5; k++)
      run_case(8 << $urandom_range(3), $urandom_range(8, 64), 1'($urandom_range(1)), -1, 15);
    run_case(64, 64, 1'b0, 12, 0);   // fatal response (R10)
    rst_n = 1'b0;
    @(negedge clk);
    chk(!halted && !mem_req_valid && next_free == '0, "R1 reset clears halt", halted, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(16, 16, 1'b0, -1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule